// File: doc/BRIEF.md
# Index-Driven Position Counter Initializer

This block owns the position count of a quadrature encoder channel. It decides, cycle by cycle, whether the count steps, is cleared, is loaded with a preset value, or wraps between two bounds. A decoder ahead of it supplies a one-cycle count strobe with a direction bit, together with the A and B phases after any swap or inversion. The raw index and home pins come in unchanged. A 3-bit policy selects one of eight ways that index pulses, home pulses, a compare value or a pair of modulo bounds act on the count.

An index event is recognised only on the first cycle in which the index pin is high while the A/B phase pair equals a programmed 2-bit pattern. Every policy acts only while the count-source select is in quadrature mode. In the three other count sources (external direction, external gate, internal timer), the block is a plain up/down counter. All outputs are registered. The strobe and the pins are single-cycle control inputs with no back-pressure, so the block carries no valid/ready handshake. Every input is accepted on every clock.

Top module: `qei_pos_init`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pos_o` is 0 and `idx_match_o`, `init_done_o` and `wrap_o` are all 0.
- R2: A cycle with `cnt_stb`=1 changes `pos_o` by one at the next edge (down when `cnt_dn`=1, up when 0), wrapping at the counter width. Without a strobe, and without any action from R5 to R10, `pos_o` holds.
- R3: An index event occurs in a cycle where `index_in`=1, `ph_b`==`match_val[1]` and `ph_a`==`match_val[0]`, provided that condition was false in the previous cycle. `idx_match_o` is 1 for exactly the cycle after each event, in every mode. An index pulse with a mismatching phase pair is not an event.
- R4: With `init_mode`=3'b000, index events leave `pos_o` unchanged.
- R5: With `init_mode`=3'b001 or 3'b111 in quadrature mode, an index event sets `pos_o` to 0 at the next edge, even if a strobe arrives in the same cycle. `init_done_o` pulses in the cycle that shows the new value.
- R6: With `init_mode`=3'b010, only the first index event after the block enters this mode (or leaves reset in it) loads `init_val` and pulses `init_done_o`. Later events leave the count alone.
- R7: With `init_mode`=3'b011, a rising edge on `home_in` arms the block, and the next index event loads `init_val` and pulses `init_done_o`. Index events with no home pulse before them are ignored.
- R8: With `init_mode`=3'b100, the second index event after a home rising edge loads `init_val`. The first such event does not.
- R9: With `init_mode`=3'b101, a cycle in which `pos_o` equals `cmp_val` makes the next value 0, whatever the strobe.
- R10: With `init_mode`=3'b110 or 3'b111, an up-strobe at `mod_hi` gives `mod_lo` and a down-strobe at `mod_lo` gives `mod_hi`. `wrap_o` pulses for that cycle. Under 3'b110, index events do not touch the count.
- R11: With `cnt_mode`≠2'b00 (2'b00 = quadrature), `init_mode` is ignored: index, home, compare and bounds have no effect, `init_done_o` and `wrap_o` stay 0, and the count follows R2 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_mode | input | 2 | Count source; 2'b00 quadrature, others external/timer |
| init_mode | input | 3 | Initialization policy select |
| match_val | input | 2 | Phase pattern {B,A} that qualifies an index |
| ph_a | input | 1 | Corrected A phase |
| ph_b | input | 1 | Corrected B phase |
| index_in | input | 1 | Index pin |
| home_in | input | 1 | Home pin |
| cnt_stb | input | 1 | One-cycle count strobe from the decoder |
| cnt_dn | input | 1 | Direction of the strobe, 1 = down |
| init_val | input | W | Value loaded by the index-load policies |
| cmp_val | input | W | Compare value for the compare-reset policy |
| mod_lo | input | W | Lower modulo bound |
| mod_hi | input | W | Upper modulo bound |
| pos_o | output | W | Position count |
| idx_match_o | output | 1 | Index event seen in the previous cycle |
| init_done_o | output | 1 | Count was cleared or loaded by an index event |
| wrap_o | output | 1 | Count wrapped between modulo bounds |

## Verification
The assertions take for granted that `mod_lo` does not exceed `mod_hi` and that the bounds, compare value and modes stay stable across the cycle a check spans. The property on the modulo wrap reads the bounds through $past, so they must not change in the cycle of the wrap. The stimulus changes configuration only between scenarios, on cycles with no strobe or index pulse pending. It always drops the index and home pins for at least one cycle between pulses, so each pulse gives exactly one edge.

// File: rtl/qei_init_pkg.sv
package qei_init_pkg;

  typedef enum logic [2:0] {
    IM_NONE      = 3'b000,
    IM_RST_EVERY = 3'b001,
    IM_LOAD_NEXT = 3'b010,
    IM_HOME_1ST  = 3'b011,
    IM_HOME_2ND  = 3'b100,
    IM_CMP_RST   = 3'b101,
    IM_MOD       = 3'b110,
    IM_MOD_RST   = 3'b111
  } init_mode_e;

  typedef enum logic [1:0] {
    CM_QUAD     = 2'b00,
    CM_EXT_DIR  = 2'b01,
    CM_EXT_GATE = 2'b10,
    CM_TIMER    = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'b00,
    SQ_ARMED = 2'b01,
    SQ_SEEN  = 2'b10
  } seq_state_e;

endpackage

// File: rtl/qei_evt_detect.sv
module qei_evt_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ph_a,
  input  logic       ph_b,
  input  logic       index_in,
  input  logic       home_in,
  input  logic [1:0] match_val,
  output logic       idx_evt,
  output logic       home_evt
);

  logic qual;
  logic qual_q;
  logic home_q;

  assign qual     = index_in && (ph_b == match_val[1]) && (ph_a == match_val[0]);
  assign idx_evt  = qual && !qual_q;
  assign home_evt = home_in && !home_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual_q <= 1'b0;
      home_q <= 1'b0;
    end else begin
      qual_q <= qual;
      home_q <= home_in;
    end
  end

  // R3
  idx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_evt |=> !idx_evt);

  // R3
  idx_needs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !index_in |-> !idx_evt);

endmodule

// File: rtl/qei_load_seq.sv
module qei_load_seq
  import qei_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  init_mode_e mode,
  input  logic       idx_evt,
  input  logic       home_evt,
  output logic       load_req
);

  seq_state_e st_q;
  seq_state_e st_d;
  init_mode_e mode_q;
  logic       armed_q;
  logic       home_mode;

  assign home_mode = (mode == IM_HOME_1ST) || (mode == IM_HOME_2ND);

  always_comb begin
    st_d = st_q;
    if (!active || !home_mode) begin
      st_d = SQ_IDLE;
    end else begin
      case (st_q)
        SQ_IDLE:  if (home_evt) st_d = SQ_ARMED;
        SQ_ARMED: if (idx_evt)  st_d = (mode == IM_HOME_1ST) ? SQ_IDLE : SQ_SEEN;
        SQ_SEEN:  if (idx_evt)  st_d = SQ_IDLE;
        default:  st_d = SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    load_req = 1'b0;
    if (active && idx_evt) begin
      case (mode)
        IM_LOAD_NEXT: load_req = armed_q;
        IM_HOME_1ST:  load_req = (st_q == SQ_ARMED);
        IM_HOME_2ND:  load_req = (st_q == SQ_SEEN);
        default:      load_req = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      mode_q  <= IM_NONE;
      armed_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      mode_q <= mode;
      if (mode != mode_q) begin
        armed_q <= 1'b1;
      end else if (load_req && (mode == IM_LOAD_NEXT)) begin
        armed_q <= 1'b0;
      end
    end
  end

  // R7
  seq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active || !home_mode) |=> (st_q == SQ_IDLE));

  // R8
  seen_after_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_SEEN) |-> ($past(st_q) != SQ_IDLE));

endmodule

// File: rtl/qei_pos_next.sv
module qei_pos_next
  import qei_init_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] pos,
  input  logic         stb,
  input  logic         dn,
  input  logic         active,
  input  init_mode_e   mode,
  input  logic         idx_evt,
  input  logic         load_req,
  input  logic [W-1:0] init_val,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] nxt,
  output logic         done,
  output logic         wrap
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] stepped;
  logic         is_mod;
  logic         idx_clear;

  assign stepped   = dn ? (pos - ONE) : (pos + ONE);
  assign is_mod    = (mode == IM_MOD) || (mode == IM_MOD_RST);
  assign idx_clear = idx_evt && ((mode == IM_RST_EVERY) || (mode == IM_MOD_RST));

  always_comb begin
    nxt  = stb ? stepped : pos;
    done = 1'b0;
    wrap = 1'b0;
    if (active) begin
      if (idx_clear) begin
        nxt  = ZERO;
        done = 1'b1;
      end else if (load_req) begin
        nxt  = init_val;
        done = 1'b1;
      end else if ((mode == IM_CMP_RST) && (pos == cmp_val)) begin
        nxt = ZERO;
      end else if (is_mod && stb) begin
        if (!dn && (pos == hi)) begin
          nxt  = lo;
          wrap = 1'b1;
        end else if (dn && (pos == lo)) begin
          nxt  = hi;
          wrap = 1'b1;
        end
      end
    end
  end

  // R10
  always_comb begin
    wrap_excl_chk: assert (!(wrap && done));
  end

endmodule

// File: rtl/qei_pos_init.sv
module qei_pos_init
  import qei_init_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   cnt_mode,
  input  logic [2:0]   init_mode,
  input  logic [1:0]   match_val,
  input  logic         ph_a,
  input  logic         ph_b,
  input  logic         index_in,
  input  logic         home_in,
  input  logic         cnt_stb,
  input  logic         cnt_dn,
  input  logic [W-1:0] init_val,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] mod_lo,
  input  logic [W-1:0] mod_hi,
  output logic [W-1:0] pos_o,
  output logic         idx_match_o,
  output logic         init_done_o,
  output logic         wrap_o
);

  init_mode_e   mode;
  logic         active;
  logic         idx_evt;
  logic         home_evt;
  logic         load_req;
  logic [W-1:0] pos_q;
  logic [W-1:0] pos_d;
  logic         done_d;
  logic         wrap_d;
  logic         idx_q;
  logic         done_q;
  logic         wrap_q;

  assign mode   = init_mode_e'(init_mode);
  assign active = (cnt_mode_e'(cnt_mode) == CM_QUAD);

  qei_evt_detect u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph_a      (ph_a),
    .ph_b      (ph_b),
    .index_in  (index_in),
    .home_in   (home_in),
    .match_val (match_val),
    .idx_evt   (idx_evt),
    .home_evt  (home_evt)
  );

  qei_load_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .mode     (mode),
    .idx_evt  (idx_evt),
    .home_evt (home_evt),
    .load_req (load_req)
  );

  qei_pos_next #(.W(W)) u_next (
    .pos      (pos_q),
    .stb      (cnt_stb),
    .dn       (cnt_dn),
    .active   (active),
    .mode     (mode),
    .idx_evt  (idx_evt),
    .load_req (load_req),
    .init_val (init_val),
    .cmp_val  (cmp_val),
    .lo       (mod_lo),
    .hi       (mod_hi),
    .nxt      (pos_d),
    .done     (done_d),
    .wrap     (wrap_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      idx_q  <= 1'b0;
      done_q <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      idx_q  <= idx_evt;
      done_q <= done_d;
      wrap_q <= wrap_d;
    end
  end

  assign pos_o       = pos_q;
  assign idx_match_o = idx_q;
  assign init_done_o = done_q;
  assign wrap_o      = wrap_q;

  // R5
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && idx_evt && ((init_mode == 3'b001) || (init_mode == 3'b111)))
      |=> ((pos_o == '0) && init_done_o));

  // R9
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (init_mode == 3'b101) && (pos_o == cmp_val)) |=> (pos_o == '0));

  // R10
  mod_up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && init_mode[2:1] == 2'b11 && !idx_evt && cnt_stb && !cnt_dn && (pos_o == mod_hi))
      |=> ((pos_o == $past(mod_lo)) && wrap_o));

  // R11
  ext_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!init_done_o && !wrap_o));

  // R4
  none_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (init_mode == 3'b000) && !cnt_stb) |=> (pos_o == $past(pos_o)));

endmodule

// File: tb/sim_qei_pos_init.sv
module sim_qei_pos_init;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cnt_mode = 2'b00;
  logic [2:0]   init_mode = 3'b000;
  logic [1:0]   match_val = 2'b11;
  logic         ph_a = 1'b0;
  logic         ph_b = 1'b0;
  logic         index_in = 1'b0;
  logic         home_in = 1'b0;
  logic         cnt_stb = 1'b0;
  logic         cnt_dn = 1'b0;
  logic [W-1:0] init_val = '0;
  logic [W-1:0] cmp_val = '1;
  logic [W-1:0] mod_lo = '0;
  logic [W-1:0] mod_hi = '1;
  logic [W-1:0] pos_o;
  logic         idx_match_o;
  logic         init_done_o;
  logic         wrap_o;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  logic [W+2:0] exp_q[$];
  string        tag_q[$];

  always #4 clk = ~clk;

  qei_pos_init #(.W(W)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_mode    (cnt_mode),
    .init_mode   (init_mode),
    .match_val   (match_val),
    .ph_a        (ph_a),
    .ph_b        (ph_b),
    .index_in    (index_in),
    .home_in     (home_in),
    .cnt_stb     (cnt_stb),
    .cnt_dn      (cnt_dn),
    .init_val    (init_val),
    .cmp_val     (cmp_val),
    .mod_lo      (mod_lo),
    .mod_hi      (mod_hi),
    .pos_o       (pos_o),
    .idx_match_o (idx_match_o),
    .init_done_o (init_done_o),
    .wrap_o      (wrap_o)
  );

  // one cycle of stimulus: called at a falling edge, returns at the next one
  task automatic cyc(input logic stb, input logic dn, input logic idx,
                     input logic hm, input logic a, input logic b,
                     input int ep, input logic ei, input logic ed,
                     input logic ew, input string tag);
    cnt_stb  = stb;
    cnt_dn   = dn;
    index_in = idx;
    home_in  = hm;
    ph_a     = a;
    ph_b     = b;
    exp_q.push_back({W'(ep), ei, ed, ew});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compares outputs just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [W+2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({pos_o, idx_match_o, init_done_o, wrap_o} !== e) begin
          errors++;
          $display("FAIL %s: pos/idx/done/wrap = %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
                   t, pos_o, idx_match_o, init_done_o, wrap_o,
                   e[W+2:3], e[2], e[1], e[0]);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while held
    checks++;
    if ({pos_o, idx_match_o, init_done_o, wrap_o} !== '0) begin
      errors++;
      $display("FAIL R1: outputs %0d/%0b/%0b/%0b expected 0/0/0/0",
               pos_o, idx_match_o, init_done_o, wrap_o);
    end
    rst_n = 1'b1;
    cyc(0,0,0,0,0,0, 0,0,0,0, "R1 after release");

    // mode 000: count, index ignored
    init_mode = 3'b000;
    cyc(1,0,0,0,0,0, 1,0,0,0, "R2 up");
    cyc(1,0,0,0,0,0, 2,0,0,0, "R2 up");
    cyc(1,0,0,0,0,0, 3,0,0,0, "R2 up");
    cyc(0,0,1,0,1,1, 3,1,0,0, "R4 index no effect");
    cyc(0,0,0,0,1,1, 3,0,0,0, "R4 hold");

    // mode 001: reset on index, priority over strobe
    init_mode = 3'b001;
    cyc(1,0,1,0,1,1, 0,1,1,0, "R5 index beats strobe");
    cyc(1,0,1,0,1,1, 1,0,0,0, "R3 held index no new event");
    cyc(1,0,0,0,1,1, 2,0,0,0, "R2 up");
    cyc(1,0,1,0,0,1, 3,0,0,0, "R3 phase mismatch");
    cyc(0,0,0,0,0,0, 3,0,0,0, "R2 hold");

    // mode 010: one-shot load
    init_mode = 3'b010;
    init_val  = 100;
    cyc(1,0,0,0,0,0, 4,0,0,0, "R2 up");
    cyc(0,0,1,0,1,1, 100,1,1,0, "R6 first index loads");
    cyc(0,0,0,0,1,1, 100,0,0,0, "R6 hold");
    cyc(0,0,1,0,1,1, 100,1,0,0, "R6 second index ignored");
    cyc(0,0,0,0,1,1, 100,0,0,0, "R6 hold");

    // mode 011: home then first index
    init_mode = 3'b011;
    init_val  = 50;
    cyc(0,0,1,0,1,1, 100,1,0,0, "R7 index before home ignored");
    cyc(0,0,0,0,1,1, 100,0,0,0, "R7 hold");
    cyc(0,0,0,1,1,1, 100,0,0,0, "R7 home");
    cyc(0,0,1,0,1,1, 50,1,1,0, "R7 load after home");
    cyc(0,0,0,0,1,1, 50,0,0,0, "R7 hold");
    cyc(0,0,1,0,1,1, 50,1,0,0, "R7 later index ignored");
    cyc(0,0,0,0,1,1, 50,0,0,0, "R7 hold");

    // mode 100: home then second index
    init_mode = 3'b100;
    init_val  = 7;
    cyc(0,0,0,1,1,1, 50,0,0,0, "R8 home");
    cyc(0,0,0,0,1,1, 50,0,0,0, "R8 hold");
    cyc(0,0,1,0,1,1, 50,1,0,0, "R8 first index no load");
    cyc(0,0,0,0,1,1, 50,0,0,0, "R8 hold");
    cyc(0,0,1,0,1,1, 7,1,1,0, "R8 second index loads");
    cyc(0,0,0,0,1,1, 7,0,0,0, "R8 hold");

    // mode 101: compare reset
    init_mode = 3'b101;
    cmp_val   = 9;
    cyc(1,0,0,0,0,0, 8,0,0,0, "R9 up");
    cyc(1,0,0,0,0,0, 9,0,0,0, "R9 reach compare");
    cyc(1,0,0,0,0,0, 0,0,0,0, "R9 compare beats strobe");
    cyc(1,0,0,0,0,0, 1,0,0,0, "R9 counts again");

    // mode 110: modulo
    init_mode = 3'b110;
    cmp_val   = '1;
    mod_lo    = 5;
    mod_hi    = 8;
    for (int k = 2; k <= 8; k++) cyc(1,0,0,0,0,0, k,0,0,0, "R2 up into range");
    cyc(1,0,0,0,0,0, 5,0,0,1, "R10 wrap up");
    cyc(1,1,0,0,0,0, 8,0,0,1, "R10 wrap down");
    cyc(1,1,0,0,0,0, 7,0,0,0, "R2 down");
    cyc(1,0,0,0,0,0, 8,0,0,0, "R2 up");
    cyc(0,0,1,0,1,1, 8,1,0,0, "R10 index ignored");
    cyc(0,0,0,0,1,1, 8,0,0,0, "R10 hold");

    // mode 111: modulo plus index reset
    init_mode = 3'b111;
    cyc(1,1,1,0,1,1, 0,1,1,0, "R5 index reset in modulo");
    cyc(1,0,0,0,1,1, 1,0,0,0, "R2 up");

    // non-quadrature count sources
    cnt_mode  = 2'b01;
    init_mode = 3'b001;
    cyc(1,0,1,0,1,1, 2,1,0,0, "R11 index ignored ext dir");
    cyc(0,0,0,0,1,1, 2,0,0,0, "R11 hold");
    cnt_mode  = 2'b11;
    init_mode = 3'b101;
    cmp_val   = 2;
    cyc(1,0,0,0,0,0, 3,0,0,0, "R11 compare ignored timer");
    cnt_mode  = 2'b10;
    init_mode = 3'b110;
    mod_lo    = 0;
    mod_hi    = 3;
    cyc(1,0,0,0,0,0, 4,0,0,0, "R11 bounds ignored gate");

    cyc(0,0,0,0,0,0, 4,0,0,0, "R2 final hold");
    repeat (2) @(negedge clk);
    done_run = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule